// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a synchronous DRAM from power-on to the point where normal traffic may begin. After reset it keeps clock enable and all data-mask lines high and drives a no-operation command for a programmable number of cycles. That hold should cover the settling time the memory needs with a stable clock, for example 200 microseconds.

After the hold it closes every bank with one precharge and waits for the row-precharge time. It then runs a group of auto-refresh commands and one load of the mode register. A configuration input chooses which of these two steps comes first. Every recovery time is given as a whole number of cycles. Once the last recovery time has run out, a ready flag rises and stays high until the next reset. A memory controller puts this block in front of its command port and hands over control when ready rises.

Top module: `sdram_boot_seq`

## Requirements
- R1: While reset is applied and in the first cycle after it is released, the command pins show no-operation, ready is low, clock enable is high and every mask bit is high. Commands are encoded as {cs_n, ras_n, cas_n, we_n}: no-operation 0111, precharge 0010, auto-refresh 0001, mode load 0000.
- R2: Counting cycles from release of reset as cycle 0, the pins show no-operation in cycles 0 to HOLD_CYC-1. Exactly one precharge is issued, in cycle HOLD_CYC.
- R3: During the precharge, address bit 10 is 1, every other address bit is 0 and the bank lines are 0.
- R4: Exactly max(REFRESH_NUM, 2) auto-refresh commands are issued. Consecutive refreshes are TRFC_CYC cycles apart.
- R5: During the mode load, address bits MODE_W-1..0 carry mode_value. Every address bit at MODE_W and above is 0, and the bank lines are 0.
- R6: mode_first is sampled in the last cycle of the precharge wait. When it is 0 the refreshes come before the mode load. When it is 1 the mode load comes first.
- R7: The first command after the precharge comes TRP_CYC cycles after it. The command after a mode load comes TMRD_CYC cycles after it. Every cycle without a listed command shows no-operation with address and bank at 0.
- R8: Ready rises in the cycle after the recovery time of the last command has run out. That cycle is the last command's cycle plus its recovery count. Ready then stays high, and no-operation is driven, until reset.
- R9: Asserting reset part-way through the sequence returns every output to its R1 state, and the whole sequence restarts from cycle 0.
- R10: Clock enable and all mask bits stay high throughout, including after ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_first | input | 1 | 1: mode load before refreshes; 0: refreshes first |
| mode_value | input | MODE_W | Value loaded into the mode register |
| cke | output | 1 | Clock enable to the memory |
| dqm | output | DQM_W | Data mask lines |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address lines |
| ba | output | BANK_W | Bank select lines |
| ready | output | 1 | High once initialization is complete |

## Verification
A wrong step counter or a wrong state shows up in the exact cycle of the next command. The command can appear early or late, appear twice, or be missing, and every command cycle is predictable from the parameters. A wrong remaining-refresh count changes how many refreshes appear before the mode load or before ready. A latched order bit that is wrong makes the mode load appear at the refresh position one recovery time after the precharge wait. A bad address path is visible in the single cycle of the precharge or the mode load. Comparing every cycle from reset until a few cycles after ready therefore exposes any such fault within one recovery period of where it arises.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

  typedef enum logic [2:0] {
    ST_HOLD,
    ST_PRE,
    ST_REF,
    ST_MRS,
    ST_DONE
  } step_e;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_PRE = 4'b0010,
    CMD_REF = 4'b0001,
    CMD_MRS = 4'b0000
  } cmd_e;

  localparam int AP_BIT = 10;

endpackage

// File: rtl/sdram_boot_timer.sv
module sdram_boot_timer #(
  parameter int CNT_W   = 8,
  parameter int RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(RST_VAL);
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_boot_cmd_drv.sv
module sdram_boot_cmd_drv
  import sdram_boot_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 2,
  parameter int MODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  step_e             step,
  input  logic [MODE_W-1:0] mode_value,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] ba
);

  cmd_e              cmd_d, cmd_q;
  logic [ADDR_W-1:0] addr_d, addr_q;

  always_comb begin
    cmd_d  = CMD_NOP;
    addr_d = '0;
    if (issue) begin
      case (step)
        ST_PRE: begin
          cmd_d          = CMD_PRE;
          addr_d[AP_BIT] = 1'b1;
        end
        ST_REF: cmd_d = CMD_REF;
        ST_MRS: begin
          cmd_d              = CMD_MRS;
          addr_d[MODE_W-1:0] = mode_value;
        end
        default: cmd_d = CMD_NOP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign addr = addr_q;
  assign ba   = '0;

endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
  import sdram_boot_pkg::*;
#(
  parameter int HOLD_CYC    = 20000,
  parameter int TRP_CYC     = 3,
  parameter int TRFC_CYC    = 7,
  parameter int TMRD_CYC    = 2,
  parameter int REFRESH_NUM = 2,
  parameter int ADDR_W      = 12,
  parameter int BANK_W      = 2,
  parameter int MODE_W      = 10,
  parameter int DQM_W       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_first,
  input  logic [MODE_W-1:0] mode_value,
  output logic              cke,
  output logic [DQM_W-1:0]  dqm,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] ba,
  output logic              ready
);

  localparam int HOLD_L  = (HOLD_CYC < 1) ? 1 : HOLD_CYC;
  localparam int TRP_L   = (TRP_CYC  < 1) ? 1 : TRP_CYC;
  localparam int TRFC_L  = (TRFC_CYC < 1) ? 1 : TRFC_CYC;
  localparam int TMRD_L  = (TMRD_CYC < 1) ? 1 : TMRD_CYC;
  localparam int REF_N   = (REFRESH_NUM < 2) ? 2 : REFRESH_NUM;
  localparam int MAX_A   = (HOLD_L > TRP_L) ? HOLD_L : TRP_L;
  localparam int MAX_B   = (TRFC_L > TMRD_L) ? TRFC_L : TMRD_L;
  localparam int MAX_DUR = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_DUR + 1);
  localparam int REF_W   = $clog2(REF_N + 1);

  step_e             state_q, state_d;
  logic [REF_W-1:0]  ref_left_q, ref_left_d;
  logic              mrs_first_q, mrs_first_d;
  logic              expired;
  logic              advance;
  logic [CNT_W-1:0]  load_val;

  assign advance = expired && (state_q != ST_DONE);

  sdram_boot_timer #(
    .CNT_W  (CNT_W),
    .RST_VAL(HOLD_L - 1)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (advance),
    .load_val(load_val),
    .expired (expired)
  );

  always_comb begin
    state_d     = state_q;
    ref_left_d  = ref_left_q;
    mrs_first_d = mrs_first_q;
    if (advance) begin
      case (state_q)
        ST_HOLD: state_d = ST_PRE;
        ST_PRE: begin
          mrs_first_d = mode_first;
          state_d     = mode_first ? ST_MRS : ST_REF;
          ref_left_d  = REF_W'(REF_N - 1);
        end
        ST_REF: begin
          if (ref_left_q != '0) begin
            ref_left_d = ref_left_q - 1'b1;
          end else begin
            state_d = mrs_first_q ? ST_DONE : ST_MRS;
          end
        end
        ST_MRS:  state_d = mrs_first_q ? ST_REF : ST_DONE;
        default: state_d = ST_DONE;
      endcase
    end
  end

  always_comb begin
    case (state_d)
      ST_PRE:  load_val = CNT_W'(TRP_L - 1);
      ST_REF:  load_val = CNT_W'(TRFC_L - 1);
      ST_MRS:  load_val = CNT_W'(TMRD_L - 1);
      default: load_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_HOLD;
      ref_left_q  <= '0;
      mrs_first_q <= 1'b0;
    end else if (advance) begin
      state_q     <= state_d;
      ref_left_q  <= ref_left_d;
      mrs_first_q <= mrs_first_d;
    end
  end

  sdram_boot_cmd_drv #(
    .ADDR_W(ADDR_W),
    .BANK_W(BANK_W),
    .MODE_W(MODE_W)
  ) u_drv (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (advance),
    .step      (state_d),
    .mode_value(mode_value),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .addr      (addr),
    .ba        (ba)
  );

  assign cke   = 1'b1;
  assign dqm   = '1;
  assign ready = (state_q == ST_DONE);

endmodule

// File: rtl/sdram_boot_chk.sv
module sdram_boot_chk #(
  parameter int ADDR_W      = 12,
  parameter int BANK_W      = 2,
  parameter int MODE_W      = 10,
  parameter int REFRESH_NUM = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [BANK_W-1:0] ba,
  input logic              ready
);

  localparam int REF_N = (REFRESH_NUM < 2) ? 2 : REFRESH_NUM;

  logic [3:0] cmd;
  logic [7:0] pre_seen, ref_seen;

  assign cmd = {cs_n, ras_n, cas_n, we_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_seen <= '0;
      ref_seen <= '0;
    end else begin
      if (cmd == 4'b0010) pre_seen <= pre_seen + 1'b1;
      if (cmd == 4'b0001) ref_seen <= ref_seen + 1'b1;
    end
  end

  p_single_pre_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0010) |-> (pre_seen == 8'd0));

  p_pre_all_banks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0010) |-> (addr == (ADDR_W'(1) << 10) && ba == '0));

  p_ref_total_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (ref_seen == 8'(REF_N)));

  p_mode_fields_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0000) |-> ((addr >> MODE_W) == '0 && ba == '0));

  p_ready_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  p_idle_after_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (cmd == 4'b0111));

endmodule

bind sdram_boot_seq sdram_boot_chk #(
  .ADDR_W     (ADDR_W),
  .BANK_W     (BANK_W),
  .MODE_W     (MODE_W),
  .REFRESH_NUM(REFRESH_NUM)
) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .cs_n (cs_n),
  .ras_n(ras_n),
  .cas_n(cas_n),
  .we_n (we_n),
  .addr (addr),
  .ba   (ba),
  .ready(ready)
);

// File: tb/sdram_boot_seq_tb.sv
module sdram_boot_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MODE_W     = 10;
  localparam int DQM_W      = 4;
  // DUT A: refresh parameter below minimum (clamped)
  localparam int A_HOLD = 37, A_TRP = 3, A_TRFC = 7, A_TMRD = 2, A_REF = 1, A_AW = 12;
  // DUT B: single-cycle precharge wait, three refreshes, wider address
  localparam int B_HOLD = 20, B_TRP = 1, B_TRFC = 4, B_TMRD = 3, B_REF = 3, B_AW = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_first = 1'b0;
  logic [MODE_W-1:0] mode_value = '0;

  logic a_cke, a_cs, a_ras, a_cas, a_we, a_rdy;
  logic [DQM_W-1:0] a_dqm;
  logic [A_AW-1:0] a_addr;
  logic [1:0] a_ba;
  logic b_cke, b_cs, b_ras, b_cas, b_we, b_rdy;
  logic [DQM_W-1:0] b_dqm;
  logic [B_AW-1:0] b_addr;
  logic [1:0] b_ba;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_boot_seq #(.HOLD_CYC(A_HOLD), .TRP_CYC(A_TRP), .TRFC_CYC(A_TRFC),
    .TMRD_CYC(A_TMRD), .REFRESH_NUM(A_REF), .ADDR_W(A_AW), .BANK_W(2),
    .MODE_W(MODE_W), .DQM_W(DQM_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_first(mode_first), .mode_value(mode_value),
    .cke(a_cke), .dqm(a_dqm), .cs_n(a_cs), .ras_n(a_ras), .cas_n(a_cas),
    .we_n(a_we), .addr(a_addr), .ba(a_ba), .ready(a_rdy));

  sdram_boot_seq #(.HOLD_CYC(B_HOLD), .TRP_CYC(B_TRP), .TRFC_CYC(B_TRFC),
    .TMRD_CYC(B_TMRD), .REFRESH_NUM(B_REF), .ADDR_W(B_AW), .BANK_W(2),
    .MODE_W(MODE_W), .DQM_W(DQM_W)) dut_b_i (
    .clk(clk), .rst_n(rst_n), .mode_first(mode_first), .mode_value(mode_value),
    .cke(b_cke), .dqm(b_dqm), .cs_n(b_cs), .ras_n(b_ras), .cas_n(b_cas),
    .we_n(b_we), .addr(b_addr), .ba(b_ba), .ready(b_rdy));

  function automatic int ref_eff(int n);
    return (n < 2) ? 2 : n;
  endfunction

  function automatic int ready_cycle(int h, int trp, int trfc, int tmrd, int n);
    return h + trp + tmrd + ref_eff(n) * trfc;
  endfunction

  function automatic logic [3:0] exp_cmd(int k, bit mf, int h, int trp, int trfc,
                                         int tmrd, int n);
    int base;
    base = h + trp;
    if (k == h) return 4'b0010;
    if (!mf) begin
      for (int i = 0; i < ref_eff(n); i++)
        if (k == base + i * trfc) return 4'b0001;
      if (k == base + ref_eff(n) * trfc) return 4'b0000;
    end else begin
      if (k == base) return 4'b0000;
      for (int i = 0; i < ref_eff(n); i++)
        if (k == base + tmrd + i * trfc) return 4'b0001;
    end
    return 4'b0111;
  endfunction

  function automatic logic [31:0] exp_addr(logic [3:0] c, logic [MODE_W-1:0] mv);
    if (c == 4'b0010) return 32'h400;
    if (c == 4'b0000) return 32'(mv);
    return 32'h0;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_cycle(int k, bit mf);
    logic [3:0] ea, eb;
    logic [31:0] xa, xb;
    ea = exp_cmd(k, mf, A_HOLD, A_TRP, A_TRFC, A_TMRD, A_REF);
    eb = exp_cmd(k, mf, B_HOLD, B_TRP, B_TRFC, B_TMRD, B_REF);
    xa = exp_addr(ea, mode_value);
    xb = exp_addr(eb, mode_value);
    // R2 R4 R6 R7: command sequence and spacing
    check({a_cs, a_ras, a_cas, a_we} == ea, $sformatf("R2 R4 R6 R7 A cmd k=%0d", k),
          32'({a_cs, a_ras, a_cas, a_we}), 32'(ea));
    check({b_cs, b_ras, b_cas, b_we} == eb, $sformatf("R2 R4 R6 R7 B cmd k=%0d", k),
          32'({b_cs, b_ras, b_cas, b_we}), 32'(eb));
    // R3 R5: address and bank contents
    check(32'(a_addr) == xa && a_ba == 2'b00, $sformatf("R3 R5 A addr k=%0d", k),
          32'(a_addr), xa);
    check(32'(b_addr) == xb && b_ba == 2'b00, $sformatf("R3 R5 B addr k=%0d", k),
          32'(b_addr), xb);
    // R8: ready timing
    check(a_rdy == (k >= ready_cycle(A_HOLD, A_TRP, A_TRFC, A_TMRD, A_REF)),
          $sformatf("R8 A ready k=%0d", k), 32'(a_rdy), 32'(k >= ready_cycle(A_HOLD, A_TRP, A_TRFC, A_TMRD, A_REF)));
    check(b_rdy == (k >= ready_cycle(B_HOLD, B_TRP, B_TRFC, B_TMRD, B_REF)),
          $sformatf("R8 B ready k=%0d", k), 32'(b_rdy), 32'(k >= ready_cycle(B_HOLD, B_TRP, B_TRFC, B_TMRD, B_REF)));
    // R10: clock enable and masks
    check(a_cke && b_cke && (&a_dqm) && (&b_dqm), $sformatf("R10 cke/dqm k=%0d", k),
          32'({a_cke, b_cke, a_dqm, b_dqm}), 32'h3FF);
  endtask

  task automatic check_reset_state(string tag);
    // R1 and R9: outputs in their reset state
    check({a_cs, a_ras, a_cas, a_we} == 4'b0111 && !a_rdy && a_addr == '0,
          {tag, " A idle"}, 32'({a_cs, a_ras, a_cas, a_we, a_rdy}), 32'h0E);
    check({b_cs, b_ras, b_cas, b_we} == 4'b0111 && !b_rdy && b_addr == '0,
          {tag, " B idle"}, 32'({b_cs, b_ras, b_cas, b_we, b_rdy}), 32'h0E);
    check(a_cke && b_cke && (&a_dqm) && (&b_dqm), {tag, " cke/dqm"},
          32'({a_cke, b_cke}), 32'h3);
  endtask

  task automatic full_run(bit mf, logic [MODE_W-1:0] mv);
    int last;
    @(negedge clk);
    rst_n = 1'b0;
    mode_first = mf;
    mode_value = mv;
    @(negedge clk);
    check_reset_state("R1 in reset");
    rst_n = 1'b1;
    check_reset_state("R1 after release");
    last = ready_cycle(A_HOLD, A_TRP, A_TRFC, A_TMRD, A_REF);
    if (ready_cycle(B_HOLD, B_TRP, B_TRFC, B_TMRD, B_REF) > last)
      last = ready_cycle(B_HOLD, B_TRP, B_TRFC, B_TMRD, B_REF);
    for (int k = 0; k <= last + 4; k++) begin
      check_cycle(k, mf);
      @(negedge clk);
    end
  endtask

  task automatic abort_run(int stop_at);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < stop_at; k++) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_reset_state("R9 mid-sequence reset");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // directed corner cases
    full_run(1'b0, 10'h3FF);
    full_run(1'b1, 10'h000);
    full_run(1'b1, 10'h3FF);
    abort_run(A_HOLD + A_TRP + 2);
    full_run(1'b0, 10'h155);   // R9: complete sequence after an aborted one
    // random stimulus
    for (int r = 0; r < 12; r++) begin
      if (r % 3 == 0) abort_run(1 + int'($urandom_range(60)));
      full_run(1'($urandom), MODE_W'($urandom));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule